// File: doc/BRIEF.md
# Control-Word Register Datapath

This block is the execution half of a small processor. It holds seven general-purpose registers and an arithmetic/logic unit. A single packed 14-bit control word drives it on every clock edge. Two fields of the word pick the operands that go onto bus A and bus B. A third field names the register that receives the ALU result. The remaining five bits choose the ALU function. Select code zero on either bus routes an external input word onto that bus, so constants and incoming data can enter the registers.

The sequencer that produces the control words is outside the block, and so are instruction fetch and memory. Each edge performs one complete micro-operation: read two sources, compute, write one destination. At the same edge the block registers the result and the carry, zero, sign and overflow status. The result output therefore also gives read-back of any register: a pass-through operation with no destination returns the selected register.

Top module: `cw_datapath`

## Requirements
- R1: The control word `cw_i[13:0]` is split, from most to least significant, into bus-A select `[13:11]`, bus-B select `[10:8]`, destination select `[7:5]` and ALU operation `[4:0]`.
- R2: A bus select code k in 1..7 places register Rk on that bus. Code 000 places `ext_i` on it. Both buses may select the same source.
- R3: A destination code k in 1..7 writes the ALU result into Rk at the clock edge and leaves every other register unchanged. Code 000 writes no register.
- R4: Operation 00010 gives A+B mod 256. C is the carry out and V is set on signed two's-complement overflow. Example: word 010_011_001_00010 performs R1 <= R2 + R3 in one cycle.
- R5: Operation 00101 gives A-B mod 256. C is 1 when no borrow occurs (A >= B unsigned). V is set on signed overflow.
- R6: Operation 00001 gives A+1, with C the carry out and V set only when A = 0x7F. Operation 00110 gives A-1, with C = 1 unless A = 0, and V set only when A = 0x80.
- R7: Operations 00000 (pass A), 01000 (A AND B), 01010 (A OR B), 01100 (A XOR B) and 01110 (NOT A) clear C and V.
- R8: Operation 10000 shifts A right logically by one, with C taking A[0]. Operation 11000 shifts A left by one, with C taking A[7]. Both clear V.
- R9: Any other operation code passes A through unchanged and clears C and V.
- R10: Z is 1 exactly when the 8-bit result is zero, and S equals result bit 7.
- R11: `result_o` and all four status bits are registered at every edge, whatever the destination code, including 000. Sources are read before the write, so a register used as both source and destination contributes its old value.
- R12: While `rst_ni` is low, all registers, the result output and all status bits are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cw_i | input | 14 | Control word for the current cycle |
| ext_i | input | 8 | External word, selectable onto either bus with code 000 |
| result_o | output | 8 | ALU result registered at the last edge |
| flag_c_o | output | 1 | Carry / no-borrow / shifted-out bit |
| flag_z_o | output | 1 | Result is zero |
| flag_s_o | output | 1 | Result bit 7 |
| flag_v_o | output | 1 | Signed overflow |

## Verification
Reading a register and writing the same register can fall in one cycle. So can computing status and writing no register at all. The bench provokes the first with words whose destination equals one or both sources, such as R5 <= R5 + R5. It provokes the second with arithmetic words carrying destination 000 that still must move the result and flags. A behavioural reference model with plain integer registers predicts the outcome of every cycle. Results, flags and later read-backs of the registers are compared against it, which shows that old operand values were used and that a null destination left storage intact.

// File: rtl/cw_pkg.sv
package cw_pkg;

    localparam int OPR_W = 5;

    typedef enum logic [OPR_W-1:0] {
        OP_PASS = 5'b00000,
        OP_INC  = 5'b00001,
        OP_ADD  = 5'b00010,
        OP_SUB  = 5'b00101,
        OP_DEC  = 5'b00110,
        OP_AND  = 5'b01000,
        OP_OR   = 5'b01010,
        OP_XOR  = 5'b01100,
        OP_NOT  = 5'b01110,
        OP_SHR  = 5'b10000,
        OP_SHL  = 5'b11000
    } alu_op_e;

    typedef struct packed {
        logic c;
        logic z;
        logic s;
        logic v;
    } flags_t;

endpackage

// File: rtl/cw_decode.sv
module cw_decode
    import cw_pkg::*;
#(
    parameter int SEL_W = 3,
    localparam int CW_W = 3 * SEL_W + OPR_W,
    localparam int NUM_REGS = (1 << SEL_W) - 1
) (
    input  logic [CW_W-1:0]     cw_i,
    output logic [SEL_W-1:0]    sel_a_o,
    output logic [SEL_W-1:0]    sel_b_o,
    output logic [OPR_W-1:0]    opr_o,
    output logic [NUM_REGS-1:0] dst_en_o
);

    logic [SEL_W-1:0] sel_d;

    // Field order is fixed: A select, B select, destination, operation.
    assign sel_a_o = cw_i[CW_W-1 -: SEL_W];
    assign sel_b_o = cw_i[CW_W-1-SEL_W -: SEL_W];
    assign sel_d   = cw_i[OPR_W +: SEL_W];
    assign opr_o   = cw_i[OPR_W-1:0];

    // One-hot destination enable; code zero enables nothing.
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_dst
        assign dst_en_o[g] = (sel_d == SEL_W'(g + 1));
    end

endmodule

// File: rtl/cw_regfile.sv
module cw_regfile #(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 3,
    localparam int NUM_REGS = (1 << SEL_W) - 1
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic [NUM_REGS-1:0]              wr_en_i,
    input  logic [DATA_W-1:0]                wr_data_i,
    input  logic [SEL_W-1:0]                 sel_a_i,
    input  logic [SEL_W-1:0]                 sel_b_i,
    input  logic [DATA_W-1:0]                ext_i,
    output logic [DATA_W-1:0]                bus_a_o,
    output logic [DATA_W-1:0]                bus_b_o,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o
);

    logic [NUM_REGS-1:0][DATA_W-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_en_i[i]) begin
                regs_d[i] = wr_data_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // Source multiplexers read the stored values (read before write).
    always_comb begin
        bus_a_o = ext_i;
        bus_b_o = ext_i;
        for (int i = 1; i <= NUM_REGS; i++) begin
            if (sel_a_i == SEL_W'(i)) bus_a_o = regs_q[i-1];
            if (sel_b_i == SEL_W'(i)) bus_b_o = regs_q[i-1];
        end
    end

    assign regs_o = regs_q;

endmodule

// File: rtl/cw_alu.sv
module cw_alu
    import cw_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int MSB = DATA_W - 1
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [OPR_W-1:0]  op_i,
    output logic [DATA_W-1:0] res_o,
    output flags_t            flags_o
);

    logic [DATA_W:0]   sum;
    logic [DATA_W-1:0] res;
    logic              c, v;

    always_comb begin
        sum = '0;
        res = a_i;
        c   = 1'b0;
        v   = 1'b0;
        case (op_i)
            OP_ADD: begin
                sum = {1'b0, a_i} + {1'b0, b_i};
                res = sum[MSB:0];
                c   = sum[DATA_W];
                v   = (a_i[MSB] == b_i[MSB]) && (res[MSB] != a_i[MSB]);
            end
            OP_SUB: begin
                sum = {1'b0, a_i} + {1'b0, ~b_i} + (DATA_W+1)'(1);
                res = sum[MSB:0];
                c   = sum[DATA_W];
                v   = (a_i[MSB] != b_i[MSB]) && (res[MSB] != a_i[MSB]);
            end
            OP_INC: begin
                sum = {1'b0, a_i} + (DATA_W+1)'(1);
                res = sum[MSB:0];
                c   = sum[DATA_W];
                v   = res[MSB] & ~a_i[MSB];
            end
            OP_DEC: begin
                sum = {1'b0, a_i} + {1'b0, {DATA_W{1'b1}}};
                res = sum[MSB:0];
                c   = sum[DATA_W];
                v   = a_i[MSB] & ~res[MSB];
            end
            OP_AND: res = a_i & b_i;
            OP_OR:  res = a_i | b_i;
            OP_XOR: res = a_i ^ b_i;
            OP_NOT: res = ~a_i;
            OP_SHR: begin
                res = {1'b0, a_i[MSB:1]};
                c   = a_i[0];
            end
            OP_SHL: begin
                res = {a_i[MSB-1:0], 1'b0};
                c   = a_i[MSB];
            end
            default: res = a_i;
        endcase
    end

    assign res_o     = res;
    assign flags_o.c = c;
    assign flags_o.v = v;
    assign flags_o.z = (res == '0);
    assign flags_o.s = res[MSB];

endmodule

// File: rtl/cw_datapath.sv
module cw_datapath
    import cw_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 3,
    localparam int CW_W = 3 * SEL_W + OPR_W,
    localparam int NUM_REGS = (1 << SEL_W) - 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CW_W-1:0]   cw_i,
    input  logic [DATA_W-1:0] ext_i,
    output logic [DATA_W-1:0] result_o,
    output logic              flag_c_o,
    output logic              flag_z_o,
    output logic              flag_s_o,
    output logic              flag_v_o
);

    typedef struct packed {
        logic [DATA_W-1:0] result;
        flags_t            flags;
    } out_t;

    logic [SEL_W-1:0]                sel_a, sel_b;
    logic [OPR_W-1:0]                opr;
    logic [NUM_REGS-1:0]             dst_en;
    logic [DATA_W-1:0]               bus_a, bus_b, alu_res;
    flags_t                          alu_flags;
    logic [NUM_REGS-1:0][DATA_W-1:0] reg_vec;
    out_t                            out_d, out_q;

    cw_decode #(.SEL_W(SEL_W)) u_decode (
        .cw_i     (cw_i),
        .sel_a_o  (sel_a),
        .sel_b_o  (sel_b),
        .opr_o    (opr),
        .dst_en_o (dst_en)
    );

    cw_regfile #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (dst_en),
        .wr_data_i (alu_res),
        .sel_a_i   (sel_a),
        .sel_b_i   (sel_b),
        .ext_i     (ext_i),
        .bus_a_o   (bus_a),
        .bus_b_o   (bus_b),
        .regs_o    (reg_vec)
    );

    cw_alu #(.DATA_W(DATA_W)) u_alu (
        .a_i     (bus_a),
        .b_i     (bus_b),
        .op_i    (opr),
        .res_o   (alu_res),
        .flags_o (alu_flags)
    );

    // Result and status follow every micro-operation, written or not.
    always_comb begin
        out_d.result = alu_res;
        out_d.flags  = alu_flags;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign result_o = out_q.result;
    assign flag_c_o = out_q.flags.c;
    assign flag_z_o = out_q.flags.z;
    assign flag_s_o = out_q.flags.s;
    assign flag_v_o = out_q.flags.v;

endmodule

// File: rtl/cw_datapath_chk.sv
module cw_datapath_chk
    import cw_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 3,
    localparam int CW_W = 3 * SEL_W + OPR_W,
    localparam int NUM_REGS = (1 << SEL_W) - 1
) (
    input logic                             clk_i,
    input logic                             rst_ni,
    input logic [CW_W-1:0]                  cw_i,
    input logic [DATA_W-1:0]                ext_i,
    input logic [DATA_W-1:0]                result_o,
    input logic                             flag_c_o,
    input logic                             flag_z_o,
    input logic                             flag_s_o,
    input logic [NUM_REGS-1:0][DATA_W-1:0]  reg_vec_i
);

    logic [SEL_W-1:0] dst_code;
    logic [SEL_W-1:0] dst_prev;
    logic [SEL_W-1:0] dst_idx;

    assign dst_code = cw_i[OPR_W +: SEL_W];
    assign dst_idx  = dst_prev - SEL_W'(1);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) dst_prev <= '0;
        else         dst_prev <= dst_code;
    end

    p_noload_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dst_code == '0) |=> $stable(reg_vec_i));

    p_dest_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dst_code != '0) |=> (reg_vec_i[dst_idx] == result_o));

    p_zero_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (flag_z_o == (result_o == '0)));

    p_sign_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (flag_s_o == result_o[DATA_W-1]));

    p_add_ext_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((cw_i[CW_W-1 -: 2*SEL_W] == '0) && (cw_i[OPR_W-1:0] == OP_ADD))
        |=> ((result_o == {$past(ext_i[DATA_W-2:0]), 1'b0})
             && (flag_c_o == $past(ext_i[DATA_W-1]))));

endmodule

bind cw_datapath cw_datapath_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W)) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cw_i      (cw_i),
    .ext_i     (ext_i),
    .result_o  (result_o),
    .flag_c_o  (flag_c_o),
    .flag_z_o  (flag_z_o),
    .flag_s_o  (flag_s_o),
    .reg_vec_i (reg_vec)
);

// File: tb/cw_datapath_tb_top.sv
module cw_datapath_tb_top;

    localparam int CLK_HALF = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic [13:0] cw = '0;
    logic [7:0]  ext = '0;
    logic [7:0]  result;
    logic        fc, fz, fs, fv;

    int checks = 0;
    int fails  = 0;

    int mregs[8];
    int exp_res, exp_c, exp_z, exp_s, exp_v;

    always #(CLK_HALF) clk = ~clk;

    cw_datapath dut_i (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .cw_i     (cw),
        .ext_i    (ext),
        .result_o (result),
        .flag_c_o (fc),
        .flag_z_o (fz),
        .flag_s_o (fs),
        .flag_v_o (fv)
    );

    function automatic int sgn(input int x);
        return (x > 127) ? x - 256 : x;
    endfunction

    // Behavioural reference of one ALU operation.
    function automatic void model_alu(input int op, input int a, input int b,
                                      output int r, output int c, output int v);
        int t;
        c = 0; v = 0;
        case (op)
            2:  begin t = a + b; r = t % 256; c = (t > 255) ? 1 : 0;
                      t = sgn(a) + sgn(b); v = (t > 127 || t < -128) ? 1 : 0; end
            5:  begin r = (a - b + 256) % 256; c = (a >= b) ? 1 : 0;
                      t = sgn(a) - sgn(b); v = (t > 127 || t < -128) ? 1 : 0; end
            1:  begin r = (a + 1) % 256; c = (a == 255) ? 1 : 0; v = (a == 127) ? 1 : 0; end
            6:  begin r = (a + 255) % 256; c = (a != 0) ? 1 : 0; v = (a == 128) ? 1 : 0; end
            8:  r = a & b;
            10: r = a | b;
            12: r = a ^ b;
            14: r = 255 - a;
            16: begin r = a / 2; c = a % 2; end
            24: begin r = (a * 2) % 256; c = a / 128; end
            default: r = a;
        endcase
    endfunction

    function automatic logic [13:0] mk(input int sa, input int sb, input int sd, input int op);
        return {3'(sa), 3'(sb), 3'(sd), 5'(op)};
    endfunction

    task automatic compare(input string tag);
        checks++;
        if (result !== 8'(exp_res) || fc !== 1'(exp_c) || fz !== 1'(exp_z) ||
            fs !== 1'(exp_s) || fv !== 1'(exp_v)) begin
            fails++;
            $display("FAIL %s: got res=%h c=%b z=%b s=%b v=%b exp res=%h c=%0d z=%0d s=%0d v=%0d",
                     tag, result, fc, fz, fs, fv, 8'(exp_res), exp_c, exp_z, exp_s, exp_v);
        end
    endtask

    // Drive one word at a falling edge, update the model, check one cycle later.
    task automatic apply(input logic [13:0] w, input logic [7:0] e, input string tag);
        int a, b, r, c, v, sa, sb, sd;
        sa = int'(w[13:11]); sb = int'(w[10:8]); sd = int'(w[7:5]);
        a = (sa == 0) ? int'(e) : mregs[sa];
        b = (sb == 0) ? int'(e) : mregs[sb];
        model_alu(int'(w[4:0]), a, b, r, c, v);
        if (sd != 0) mregs[sd] = r;
        exp_res = r; exp_c = c; exp_v = v;
        exp_z = (r == 0) ? 1 : 0;
        exp_s = (r > 127) ? 1 : 0;
        cw = w; ext = e;
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic readback(input string tag);
        for (int k = 1; k <= 7; k++) apply(mk(k, 0, 0, 0), 8'h00, tag);
    endtask

    initial begin
        #(CLK_HALF * 2 * 200000);
        fails++; checks++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int k = 0; k < 8; k++) mregs[k] = 0;
        #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: state during reset
        exp_res = 0; exp_c = 0; exp_z = 0; exp_s = 0; exp_v = 0;
        compare("R12 reset outputs");
        rst_n = 1'b1;
        readback("R12 registers cleared");

        // R2 R3: load R1..R7 from the external word
        for (int k = 1; k <= 7; k++) apply(mk(0, 0, k, 0), 8'(k * 17 + 3), "R3 load");
        readback("R2 read each register");

        // R4: the example word R1 <= R2 + R3, then read R1
        apply(14'b010_011_001_00010, 8'h00, "R4 example add");
        apply(mk(1, 0, 0, 0), 8'h00, "R4 R1 after add");
        // R1: field placement with distinct fields (R7 - R4 into R6)
        apply(mk(7, 4, 6, 5), 8'h00, "R1 field order");
        apply(mk(6, 0, 0, 0), 8'h00, "R1 R6 readback");

        // R4 corner cases through bus B = ext
        apply(mk(0, 0, 0, 2), 8'hFF, "R4 carry ext+ext");
        apply(mk(0, 0, 0, 2), 8'h40, "R4 overflow 40+40");
        apply(mk(0, 0, 2, 0), 8'h80, "R4 load 80");
        apply(mk(2, 0, 0, 2), 8'h80, "R4 zero carry overflow");

        // R5
        apply(mk(0, 0, 3, 0), 8'h05, "R5 load");
        apply(mk(3, 0, 0, 5), 8'h07, "R5 borrow");
        apply(mk(3, 0, 0, 5), 8'h05, "R5 equal zero");
        apply(mk(2, 0, 0, 5), 8'h01, "R5 signed overflow");

        // R6
        apply(mk(0, 0, 0, 1), 8'hFF, "R6 inc wrap");
        apply(mk(0, 0, 0, 1), 8'h7F, "R6 inc overflow");
        apply(mk(0, 0, 0, 6), 8'h00, "R6 dec zero");
        apply(mk(0, 0, 0, 6), 8'h80, "R6 dec overflow");

        // R7 R8 R9 with A = R4, B = ext
        apply(mk(0, 0, 4, 0), 8'hA5, "R7 load");
        apply(mk(4, 0, 0, 8),  8'h3C, "R7 and");
        apply(mk(4, 0, 0, 10), 8'h3C, "R7 or");
        apply(mk(4, 0, 0, 12), 8'hA5, "R7 xor zero");
        apply(mk(4, 0, 0, 14), 8'h00, "R7 not");
        apply(mk(4, 0, 0, 16), 8'h00, "R8 shr");
        apply(mk(4, 0, 0, 24), 8'h00, "R8 shl");
        apply(mk(4, 0, 0, 3),  8'h11, "R9 undefined 00011");
        apply(mk(4, 0, 0, 31), 8'h11, "R9 undefined 11111");

        // R11: same register as source and destination; null destination
        apply(mk(0, 0, 5, 0), 8'h21, "R11 load");
        apply(mk(5, 5, 5, 2), 8'h00, "R11 self add");
        apply(mk(5, 0, 5, 5), 8'h01, "R11 self sub");
        apply(mk(5, 5, 0, 2), 8'h00, "R11 flags without write");
        readback("R3 null destination kept registers");

        // R10 and everything: random sweep against the model
        for (int n = 0; n < 400; n++) begin
            logic [13:0] w;
            w = 14'($urandom);
            if (n % 3 == 0) w[4:0] = 5'(2 + 3 * (n % 2));
            apply(w, 8'($urandom), "R10 random");
        end
        readback("R3 final state");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule